// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from eight devices and presents a single interrupt line to a processor. Each request input is edge sensitive: a rising edge records a pending bit. Software sees the pending bits, can disable lines through a mask register it reads and writes, and sees which handlers are in progress through an in-service register. Line 0 ranks highest and line 7 lowest.

The interrupt line is raised only when the best unmasked pending line outranks every line already in service, so handlers nest strictly by priority. When the processor acknowledges, the winning line moves from pending to in-service in one cycle, and the block returns a vector byte. The upper bits of that byte come from a parameter and the low three bits carry the line index. An end-of-interrupt pulse from software retires the highest-priority in-service line, which may let a blocked request through.

A three-state sequencer drives the handshake. The states are Quiet (no line raised), Signal (line raised, waiting for acknowledge) and Vector (vector byte valid for one cycle). The transitions are:
- Quiet→Signal when a request is eligible.
- Signal→Vector on acknowledge while the request is still eligible.
- Signal→Quiet when eligibility is lost.
- Vector→Quiet always.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, the pending, mask and in-service registers read 0, and both `irq_out` and `vec_valid` are low.
- R2: A 0→1 transition on `irq_in[i]` sets pending bit i at the next clock edge. A line held high sets it once only, and sets it again only after it has gone low and risen again.
- R3: A line whose mask bit is 1 never causes `irq_out` to be raised. Its pending bit stays visible on `req_rdata`.
- R4: A cycle with `mask_we` high loads `mask_wdata` into the mask, and `mask_rdata` returns it from the next cycle.
- R5: `irq_out` goes high one cycle after an unmasked pending line exists whose index is lower than every in-service index, or when nothing is in service.
- R6: A pending line whose index is equal to or greater than the lowest in-service index does not raise `irq_out`.
- R7: `ack` while `irq_out` is high and a request is eligible clears that line's pending bit and sets its in-service bit. In the next cycle only, `vec_valid` is high and `vec_out` equals `VEC_BASE` with its low 3 bits replaced by the line index (base 0x20 gives 0x20 + index).
- R8: Among several eligible pending lines, acknowledge selects the lowest index.
- R9: An `eoi` pulse clears only the lowest-index set in-service bit. A pending request that it blocked then raises `irq_out`.
- R10: `ack` while `irq_out` is low changes no register and produces no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Device request lines, rising-edge detected |
| ack | input | 1 | Processor acknowledge pulse |
| eoi | input | 1 | End-of-interrupt command pulse |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write value, 1 disables a line |
| mask_rdata | output | 8 | Current mask |
| req_rdata | output | 8 | Pending request bits |
| svc_rdata | output | 8 | In-service bits |
| irq_out | output | 1 | Interrupt line to processor |
| vec_valid | output | 1 | Vector byte valid, one cycle |
| vec_out | output | 8 | Vector byte |

## Verification
Directed patterns are applied first:
- A single line held high separates edge capture from level capture.
- A second edge on a line already in service shows that equal priority does not preempt.
- A simultaneous pair on lines 3 and 6 checks that the lowest index wins.
- A higher-priority request arriving during service confirms nesting, and the following end-of-interrupt commands confirm that only the top in-service bit is retired.
- Masking a pending line, and acknowledging with no line raised, show that neither disturbs the registers.

A seeded random phase then mixes toggling lines with acknowledge, end-of-interrupt and mask writes. Every register and output is compared each cycle against a priority model built from the requirements.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_SIGNAL = 2'd1,
        ST_VECTOR = 2'd2
    } nic_state_e;
endpackage

// File: rtl/nic_edge_detect.sv
module nic_edge_detect #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_i,
    output logic [N_LINES-1:0] rise_o
);
    logic [N_LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines_i;
    end

    // per-line rising-edge detector
    for (genvar g = 0; g < N_LINES; g++) begin : g_rise
        assign rise_o[g] = lines_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [N_LINES-1:0] onehot_o
);
    // lowest index has highest priority
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign onehot_o = vec_i & ~(vec_i - N_LINES'(1));
endmodule

// File: rtl/nic_seq_fsm.sv
module nic_seq_fsm
    import nic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eligible_i,
    input  logic ack_i,
    output logic grant_o,
    output logic irq_o,
    output logic vec_valid_o
);
    nic_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        grant_o = 1'b0;
        unique case (state_q)
            ST_QUIET:  if (eligible_i) state_d = ST_SIGNAL;
            ST_SIGNAL: begin
                if (!eligible_i) begin
                    state_d = ST_QUIET;
                end else if (ack_i) begin
                    grant_o = 1'b1;
                    state_d = ST_VECTOR;
                end
            end
            ST_VECTOR: state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq_o       = (state_q == ST_SIGNAL);
        vec_valid_o = (state_q == ST_VECTOR);
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int             N_LINES  = 8,
    parameter int             VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               ack,
    input  logic               eoi,
    input  logic               mask_we,
    input  logic [N_LINES-1:0] mask_wdata,
    output logic [N_LINES-1:0] mask_rdata,
    output logic [N_LINES-1:0] req_rdata,
    output logic [N_LINES-1:0] svc_rdata,
    output logic               irq_out,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);
    localparam int IDX_W = $clog2(N_LINES);

    logic [N_LINES-1:0] req_q, mask_q, svc_q;
    logic [VEC_W-1:0]   vec_q;
    logic [N_LINES-1:0] rise;
    logic               req_found, svc_found, eligible, grant;
    logic [IDX_W-1:0]   req_idx, svc_idx;
    logic [N_LINES-1:0] req_onehot, svc_onehot;
    logic [N_LINES-1:0] grant_bits, retire_bits;

    nic_edge_detect #(.N_LINES(N_LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_in),
        .rise_o  (rise)
    );

    nic_prio_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_req_pick (
        .vec_i    (req_q & ~mask_q),
        .found_o  (req_found),
        .idx_o    (req_idx),
        .onehot_o (req_onehot)
    );

    nic_prio_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_svc_pick (
        .vec_i    (svc_q),
        .found_o  (svc_found),
        .idx_o    (svc_idx),
        .onehot_o (svc_onehot)
    );

    // strictly higher priority than everything in service
    assign eligible = req_found && (!svc_found || (req_idx < svc_idx));

    nic_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .eligible_i  (eligible),
        .ack_i       (ack),
        .grant_o     (grant),
        .irq_o       (irq_out),
        .vec_valid_o (vec_valid)
    );

    assign grant_bits  = grant ? req_onehot : '0;
    assign retire_bits = eoi   ? svc_onehot : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            svc_q  <= '0;
            mask_q <= '0;
            vec_q  <= '0;
        end else begin
            req_q <= (req_q | rise) & ~grant_bits;
            svc_q <= (svc_q & ~retire_bits) | grant_bits;
            if (mask_we) mask_q <= mask_wdata;
            if (grant)   vec_q  <= {VEC_BASE[VEC_W-1:IDX_W], req_idx};
        end
    end

    assign mask_rdata = mask_q;
    assign req_rdata  = req_q;
    assign svc_rdata  = svc_q;
    assign vec_out    = vec_q;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int               N_LINES  = 8,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h20
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irq_in,
    input logic               eoi,
    input logic [N_LINES-1:0] mask_rdata,
    input logic [N_LINES-1:0] req_rdata,
    input logic [N_LINES-1:0] svc_rdata,
    input logic               irq_out,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_out
);
    localparam int IDX_W = $clog2(N_LINES);

    assert_req_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_rdata & ~$past(req_rdata) & ~$past(irq_in)) == '0));

    assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ($past(req_rdata & ~mask_rdata) != '0));

    assert_vec_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[VEC_W-1:IDX_W] == VEC_BASE[VEC_W-1:IDX_W]));

    assert_vec_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> svc_rdata[vec_out[IDX_W-1:0]]);

    assert_svc_gain_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((svc_rdata & ~$past(svc_rdata)) != '0) |-> vec_valid);

    assert_eoi_retires_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eoi) && ($past(svc_rdata) != '0) && !vec_valid)
            |-> ($countones(svc_rdata) + 1 == $countones($past(svc_rdata))));
endmodule

bind nest_irq_ctrl nic_checker #(
    .N_LINES  (N_LINES),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
) u_nic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .eoi        (eoi),
    .mask_rdata (mask_rdata),
    .req_rdata  (req_rdata),
    .svc_rdata  (svc_rdata),
    .irq_out    (irq_out),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
    localparam logic [7:0] BASE = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       ack = 1'b0, eoi = 1'b0, mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] mask_rdata, req_rdata, svc_rdata, vec_out;
    logic       irq_out, vec_valid;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_req = '0, m_mask = '0, m_svc = '0, m_prev = '0, m_vec = '0;
    int         m_state = 0;  // 0 quiet, 1 signal, 2 vector

    always #2 clk = ~clk;

    nest_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .eoi(eoi),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .req_rdata(req_rdata), .svc_rdata(svc_rdata), .irq_out(irq_out),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    function automatic int top_idx(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] lines, input logic a, input logic e,
                        input logic we, input logic [7:0] wd);
        int w, h, nst;
        logic elig, grant;
        logic [7:0] rise;
        @(negedge clk);
        irq_in = lines; ack = a; eoi = e; mask_we = we; mask_wdata = wd;
        rise  = lines & ~m_prev;
        w     = top_idx(m_req & ~m_mask);
        h     = top_idx(m_svc);
        elig  = (w < 8) && (w < h);
        grant = (m_state == 1) && a && elig;
        nst   = (m_state == 0) ? (elig ? 1 : 0)
              : (m_state == 1) ? (!elig ? 0 : (a ? 2 : 1)) : 0;
        if (e && h < 8) m_svc[h] = 1'b0;
        m_req = m_req | rise;
        if (grant) begin
            m_req[w] = 1'b0;
            m_svc[w] = 1'b1;
            m_vec = {BASE[7:3], 3'(w)};
        end
        if (we) m_mask = wd;
        m_prev = lines;
        m_state = nst;
        @(posedge clk);
        #1;
        chk("R5 irq_out model", 32'(irq_out), 32'(m_state == 1));
        chk("R7 vec_valid model", 32'(vec_valid), 32'(m_state == 2));
        if (m_state == 2) chk("R7 vector model", 32'(vec_out), 32'(m_vec));
        chk("R2 pending model", 32'(req_rdata), 32'(m_req));
        chk("R4 mask model", 32'(mask_rdata), 32'(m_mask));
        chk("R9 in-service model", 32'(svc_rdata), 32'(m_svc));
    endtask

    task automatic idle(input logic [7:0] lines);
        step(lines, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pending", 32'(req_rdata), 0);
        chk("R1 mask", 32'(mask_rdata), 0);
        chk("R1 in-service", 32'(svc_rdata), 0);
        chk("R1 irq_out", 32'(irq_out), 0);
        chk("R1 vec_valid", 32'(vec_valid), 0);

        // R2 single edge, then held high
        idle(8'h10);
        chk("R2 edge sets bit", 32'(req_rdata), 32'h10);
        idle(8'h10);
        chk("R5 irq raised", 32'(irq_out), 1);
        step(8'h10, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R7 vec_valid", 32'(vec_valid), 1);
        chk("R7 vector line4", 32'(vec_out), 32'h24);
        chk("R7 pending cleared", 32'(req_rdata), 0);
        chk("R7 in-service set", 32'(svc_rdata), 32'h10);
        idle(8'h10); idle(8'h10); idle(8'h10);
        chk("R2 held line not re-requested", 32'(req_rdata), 0);
        chk("R7 single-cycle vector", 32'(vec_valid), 0);

        // R6 equal priority blocked
        idle(8'h00); idle(8'h10); idle(8'h00); idle(8'h00);
        chk("R6 pending again", 32'(req_rdata), 32'h10);
        chk("R6 equal priority blocked", 32'(irq_out), 0);
        step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R9 eoi clears", 32'(svc_rdata), 0);
        idle(8'h00);
        chk("R9 release raises irq", 32'(irq_out), 1);
        step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
        step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);

        // R8 simultaneous lines 3 and 6
        idle(8'h48);
        chk("R8 both pending", 32'(req_rdata), 32'h48);
        idle(8'h00);
        step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R8 lowest index wins", 32'(vec_out), 32'h23);
        chk("R8 in-service", 32'(svc_rdata), 32'h08);

        // nesting: line 1 preempts line 3
        idle(8'h02);
        idle(8'h00);
        chk("R5 higher priority nests", 32'(irq_out), 1);
        step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R7 nested vector", 32'(vec_out), 32'h21);
        chk("R7 nested in-service", 32'(svc_rdata), 32'h0A);
        idle(8'h00); idle(8'h00);
        chk("R6 lower priority blocked", 32'(irq_out), 0);
        step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R9 top bit only", 32'(svc_rdata), 32'h08);
        step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
        idle(8'h00); idle(8'h00);
        chk("R9 line6 released", 32'(irq_out), 1);

        // R3 / R4 masking
        step(8'h00, 1'b0, 1'b0, 1'b1, 8'h40);
        idle(8'h00); idle(8'h00);
        chk("R3 masked line quiet", 32'(irq_out), 0);
        chk("R3 pending kept", 32'(req_rdata), 32'h40);
        chk("R4 mask readback", 32'(mask_rdata), 32'h40);
        step(8'h00, 1'b0, 1'b0, 1'b1, 8'h00);
        idle(8'h00);
        chk("R3 unmask raises", 32'(irq_out), 1);
        step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R7 vector line6", 32'(vec_out), 32'h26);
        step(8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
        idle(8'h00);

        // R10 ack with line low
        step(8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R10 no vector", 32'(vec_valid), 0);
        chk("R10 in-service unchanged", 32'(svc_rdata), 0);
        chk("R10 pending unchanged", 32'(req_rdata), 0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] ln, wd;
            logic a, e, we;
            ln = 8'($urandom) & 8'($urandom);
            a  = ($urandom % 3) == 0;
            e  = ($urandom % 8) == 0;
            we = ($urandom % 16) == 0;
            wd = 8'($urandom) & 8'($urandom);
            step(ln, a, e, we, wd);
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule